// File: doc/BRIEF.md
# Serial Character Receiver with Status Flags

This block takes an asynchronous serial line and turns it into characters that a host collects through a small register port. A 16x oversampling engine finds each start bit and confirms it by a three-sample majority vote near the bit centre. It then collects eight or nine data bits, least significant first, and samples the stop bit. Each finished character is handed to a single-entry holding register together with its ninth bit and its framing result. A divider input sets the oversampling rate: one tick every `baud_div + 1` clocks.

The host sees three registers. The data register returns the held character, and reading it empties the holder. The status register reports receive-complete, framing-error and overrun. The control register holds the interrupt enable, the receiver enable and the nine-bit mode switch, and shows the received ninth bit as a read-only field. The serial side cannot be stalled. The only back-pressure is the overrun flag: a character that ends while the holder is still full is dropped, and the flag records the loss next to the older, still-valid character. The interrupt line is high while a character waits and the interrupt enable is on.

Register map (`reg_addr`): 0 = data, 1 = status, 2 = control, 3 reads zero. Status bits: 7 receive-complete, 4 framing error, 3 overrun, all others zero. Control bits: 7 interrupt enable, 4 receiver enable, 2 nine-bit mode (all read/write), 1 received ninth bit (read-only), others read zero.

Top module: `uart_rx_top`

## Requirements
- R1: After reset the data, status and control registers all read 0x00 and `irq` is low.
- R2: In eight-bit mode a frame is a low start bit, eight data bits sent least significant first, and a stop bit. Its data appears in the data register and sets status bit 7.
- R3: With control bit 2 set, nine data bits are received. The ninth bit reads in control bit 1, and the low eight bits read in the data register. In eight-bit mode control bit 1 reads 0.
- R4: Status bit 4 is set when the stop bit samples low. It is cleared when a character with a high stop bit is stored.
- R5: A character that completes while status bit 7 is set is discarded, the held data stays unchanged, and status bit 3 is set. Status bit 3 is cleared when the next character is stored.
- R6: A read of the data register clears status bit 7 on the following cycle, unless a new character is stored in that same cycle.
- R7: While control bit 4 is low, status bits 7, 4 and 3 never become set, and flags that are already set keep their values.
- R8: `irq` is high exactly when status bit 7 and control bit 7 are both set.
- R9: A low pulse that does not hold through the majority samples at the bit centre is treated as a false start. The receiver returns to idle, stores nothing, and then receives the next valid frame correctly.
- R10: Status bits 6, 5, 2, 1 and 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| baud_div | input | DIV_W | Oversampling tick period minus one |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data register) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
A wrong sampler phase or bit index corrupts the data byte read in the next host access after the frame ends. A bit index that never reaches its end leaves receive-complete low for good, and that shows one stop-bit time later. Faults in the flag logic show on the status read that follows a single crafted frame: an overrun that fails to stick or a held byte that is overwritten, a framing flag that does not follow the last stored stop bit, or flags that move while the receiver is disabled. Interrupt faults show on the same cycle on `irq`, compared against the status and control read-back.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  localparam int ST_DONE = 7;
  localparam int ST_FE   = 4;
  localparam int ST_OVR  = 3;

  localparam int CT_IRQEN = 7;
  localparam int CT_RXEN  = 4;
  localparam int CT_NINE  = 2;
  localparam int CT_BIT9  = 1;

  localparam int CHAR_MAX = 9;

  typedef enum logic [1:0] {SM_IDLE, SM_START, SM_DATA, SM_STOP} smp_state_e;

  typedef struct packed {
    logic [CHAR_MAX-1:0] bits;
    logic                stop_ok;
  } rx_frame_t;
endpackage

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_comb tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      nine,
  input  logic      tick,
  input  logic      rxd,
  output logic      frm_valid,
  output rx_frame_t frm
);
  localparam int PW     = $clog2(OSR);
  localparam int MID    = OSR / 2;
  localparam int IW     = $clog2(CHAR_MAX + 1);
  localparam logic [PW-1:0] PH_V0   = PW'(MID - 1);
  localparam logic [PW-1:0] PH_V1   = PW'(MID);
  localparam logic [PW-1:0] PH_DEC  = PW'(MID + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);

  logic [1:0]          sync_q;
  logic                rxd_s;
  smp_state_e          state_q;
  logic [PW-1:0]       phase_q;
  logic [1:0]          votes_q;
  logic [IW-1:0]       idx_q;
  logic [CHAR_MAX-1:0] shreg_q;
  logic                maj;
  logic [IW-1:0]       last_idx;

  assign rxd_s    = sync_q[1];
  assign maj      = (votes_q[1] & votes_q[0]) | (votes_q[1] & rxd_s) | (votes_q[0] & rxd_s);
  assign last_idx = nine ? IW'(CHAR_MAX - 1) : IW'(CHAR_MAX - 2);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SM_IDLE;
      phase_q   <= '0;
      votes_q   <= 2'b11;
      idx_q     <= '0;
      shreg_q   <= '0;
      frm_valid <= 1'b0;
      frm       <= '0;
    end else begin
      frm_valid <= 1'b0;
      if (!enable) begin
        state_q <= SM_IDLE;
        phase_q <= '0;
      end else if (tick) begin
        if (state_q == SM_IDLE) begin
          if (!rxd_s) begin
            state_q <= SM_START;
            phase_q <= PW'(1);
          end
        end else begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
          if (phase_q == PH_V0 || phase_q == PH_V1)
            votes_q <= {votes_q[0], rxd_s};
          if (phase_q == PH_DEC) begin
            case (state_q)
              SM_START: begin
                if (maj) begin
                  state_q <= SM_IDLE;
                end else begin
                  state_q <= SM_DATA;
                  idx_q   <= '0;
                  shreg_q <= '0;
                end
              end
              SM_DATA: begin
                shreg_q[idx_q] <= maj;
                if (idx_q == last_idx) state_q <= SM_STOP;
                else                   idx_q   <= idx_q + 1'b1;
              end
              SM_STOP: begin
                frm_valid   <= 1'b1;
                frm.stop_ok <= maj;
                frm.bits    <= nine ? shreg_q : {1'b0, shreg_q[CHAR_MAX-2:0]};
                state_q     <= SM_IDLE;
              end
              default: state_q <= SM_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              frm_valid,
  input  rx_frame_t         frm,
  output logic              ctl_rx_en,
  output logic              ctl_nine,
  output logic              ctl_irq_en,
  output logic              flag_done,
  output logic              flag_fe,
  output logic              flag_ovr,
  output logic [7:0]        hold_data,
  output logic              hold_bit9,
  output logic              irq
);
  logic rd_data;
  logic accept;
  logic still_full;
  logic unused_wbits;

  assign rd_data      = reg_rd && (reg_addr == ADDR_DATA);
  assign accept       = frm_valid && ctl_rx_en;
  assign still_full   = flag_done && !rd_data;
  assign unused_wbits = ^{reg_wdata[6:5], reg_wdata[3], reg_wdata[1:0]};
  assign irq          = flag_done & ctl_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_rx_en  <= 1'b0;
      ctl_nine   <= 1'b0;
      ctl_irq_en <= 1'b0;
    end else if (reg_wr && reg_addr == ADDR_CTRL) begin
      ctl_irq_en <= reg_wdata[CT_IRQEN];
      ctl_rx_en  <= reg_wdata[CT_RXEN];
      ctl_nine   <= reg_wdata[CT_NINE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_done <= 1'b0;
      flag_fe   <= 1'b0;
      flag_ovr  <= 1'b0;
      hold_data <= '0;
      hold_bit9 <= 1'b0;
    end else if (accept && still_full) begin
      flag_ovr <= 1'b1;
    end else if (accept) begin
      hold_data <= frm.bits[7:0];
      hold_bit9 <= frm.bits[CHAR_MAX-1];
      flag_fe   <= !frm.stop_ok;
      flag_ovr  <= 1'b0;
      flag_done <= 1'b1;
    end else if (rd_data) begin
      flag_done <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_DATA: reg_rdata = hold_data;
      ADDR_STAT: begin
        reg_rdata[ST_DONE] = flag_done;
        reg_rdata[ST_FE]   = flag_fe;
        reg_rdata[ST_OVR]  = flag_ovr;
      end
      ADDR_CTRL: begin
        reg_rdata[CT_IRQEN] = ctl_irq_en;
        reg_rdata[CT_RXEN]  = ctl_rx_en;
        reg_rdata[CT_NINE]  = ctl_nine;
        reg_rdata[CT_BIT9]  = hold_bit9;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic      tick;
  logic      frm_valid;
  rx_frame_t frm;
  logic      ctl_rx_en;
  logic      ctl_nine;
  logic      ctl_irq_en;
  logic      flag_done;
  logic      flag_fe;
  logic      flag_ovr;
  logic [7:0] hold_data;
  logic      hold_bit9;

  rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (baud_div),
    .tick (tick)
  );

  rx_frame_sampler #(.OSR(OSR)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctl_rx_en),
    .nine     (ctl_nine),
    .tick     (tick),
    .rxd      (rxd),
    .frm_valid(frm_valid),
    .frm      (frm)
  );

  rx_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .frm_valid (frm_valid),
    .frm       (frm),
    .ctl_rx_en (ctl_rx_en),
    .ctl_nine  (ctl_nine),
    .ctl_irq_en(ctl_irq_en),
    .flag_done (flag_done),
    .flag_fe   (flag_fe),
    .flag_ovr  (flag_ovr),
    .hold_data (hold_data),
    .hold_bit9 (hold_bit9),
    .irq       (irq)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              irq,
  input logic              frm_valid,
  input logic              ctl_rx_en,
  input logic              flag_done,
  input logic              flag_fe,
  input logic              flag_ovr,
  input logic [7:0]        hold_data
);
  // R6
  rd_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_DATA && !frm_valid) |=> !flag_done);

  // R7
  off_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rx_en |=> (!$rose(flag_done) && !$rose(flag_fe) && !$rose(flag_ovr)));

  // R7
  off_keep_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rx_en && flag_fe) |=> flag_fe);

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ctl_rx_en && flag_done && !(reg_rd && reg_addr == ADDR_DATA))
      |=> ($stable(hold_data) && flag_ovr));

  // R8
  irq_shows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && reg_addr == ADDR_STAT) |-> reg_rdata[ST_DONE]);

  // R10
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_STAT) |-> (reg_rdata[2:0] == 3'b000 && reg_rdata[6:5] == 2'b00));
endmodule

bind uart_rx_top uart_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .frm_valid(frm_valid),
  .ctl_rx_en(ctl_rx_en),
  .flag_done(flag_done),
  .flag_fe  (flag_fe),
  .flag_ovr (flag_ovr),
  .hold_data(hold_data)
);

// File: tb/uart_rx_top_test.sv
module uart_rx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [15:0] baud_div = 16'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_rx_top uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {nine, data[8:0], stop, expected framing error}
  localparam logic [11:0] VECS [10] = '{
    {1'b0, 9'h0A5, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b1, 1'b0},
    {1'b0, 9'h0FF, 1'b1, 1'b0},
    {1'b0, 9'h13C, 1'b1, 1'b0},
    {1'b0, 9'h081, 1'b0, 1'b1},
    {1'b0, 9'h07E, 1'b1, 1'b0},
    {1'b1, 9'h1C3, 1'b1, 1'b0},
    {1'b1, 9'h055, 1'b1, 1'b0},
    {1'b1, 9'h1FF, 1'b0, 1'b1},
    {1'b1, 9'h100, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = v;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] d, input logic stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i]);
    drive_bit(stop);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl_val(input logic ien, input logic en, input logic nine);
    return {ien, 2'b00, en, 1'b0, nine, 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, v); check("R1", "data after reset", v, 8'h00);
    reg_read(2'd1, v); check("R1", "status after reset", v, 8'h00);
    reg_read(2'd2, v); check("R1", "control after reset", v, 8'h00);
    check("R1", "irq after reset", {7'd0, irq}, 8'h00);

    // R2 R3 R4 R10 table walk
    for (int k = 0; k < 10; k++) begin
      logic       nine, stop, fe;
      logic [8:0] d;
      logic [7:0] c_exp;
      {nine, d, stop, fe} = VECS[k];
      reg_write(2'd2, ctrl_val(1'b0, 1'b1, nine));
      send_frame(nine, d, stop);
      reg_read(2'd1, v); check("R4", "status after frame", v, {1'b1, 2'b00, fe, 4'b0000});
      c_exp = ctrl_val(1'b0, 1'b1, nine) | {6'd0, (nine & d[8]), 1'b0};
      reg_read(2'd2, v); check("R3", "ninth bit in control", v, c_exp);
      reg_read(2'd0, v); check("R2", "received data", v, d[7:0]);
      reg_read(2'd1, v); check("R6", "status after data read", v, {3'b000, fe, 4'b0000});
    end

    // R5 overrun
    reg_write(2'd2, ctrl_val(1'b0, 1'b1, 1'b0));
    send_frame(1'b0, 9'h011, 1'b1);
    send_frame(1'b0, 9'h022, 1'b1);
    reg_read(2'd1, v); check("R5", "overrun visible with old data", v, 8'h88);
    reg_read(2'd0, v); check("R5", "old data retained", v, 8'h11);
    reg_read(2'd1, v); check("R5", "overrun stays after read", v, 8'h08);
    send_frame(1'b0, 9'h033, 1'b1);
    reg_read(2'd1, v); check("R5", "overrun cleared by new store", v, 8'h80);
    reg_read(2'd0, v); check("R5", "new data stored", v, 8'h33);

    // R8 interrupt
    send_frame(1'b0, 9'h044, 1'b1);
    @(negedge clk);
    check("R8", "irq with enable off", {7'd0, irq}, 8'h00);
    reg_write(2'd2, ctrl_val(1'b1, 1'b1, 1'b0));
    #1 check("R8", "irq with enable on", {7'd0, irq}, 8'h01);
    reg_read(2'd0, v);
    #1 check("R8", "irq after data read", {7'd0, irq}, 8'h00);

    // R7 disable freezes flags
    reg_write(2'd2, ctrl_val(1'b0, 1'b1, 1'b0));
    send_frame(1'b0, 9'h066, 1'b0);
    reg_read(2'd0, v);
    reg_write(2'd2, ctrl_val(1'b0, 1'b0, 1'b0));
    reg_read(2'd1, v); check("R7", "fe kept after disable", v, 8'h10);
    send_frame(1'b0, 9'h055, 1'b1);
    reg_read(2'd1, v); check("R7", "no set while disabled", v, 8'h10);
    reg_read(2'd0, v); check("R7", "data unchanged while disabled", v, 8'h66);
    send_frame(1'b0, 9'h0AA, 1'b0);
    reg_read(2'd1, v); check("R7", "bad frame ignored while disabled", v, 8'h10);

    // R9 false start then valid frame
    reg_write(2'd2, ctrl_val(1'b0, 1'b1, 1'b0));
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    reg_read(2'd1, v); check("R9", "glitch stores nothing", v, 8'h10);
    send_frame(1'b0, 9'h05A, 1'b1);
    reg_read(2'd1, v); check("R9", "frame after glitch status", v, 8'h80);
    reg_read(2'd0, v); check("R9", "frame after glitch data", v, 8'h5A);

    // R10 unused address reads zero, status low bits zero
    reg_read(2'd3, v); check("R10", "unused address", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule